// File: doc/BRIEF.md
# Sequential Integer Multiply/Divide Unit with Result Pair

This block computes 32-bit integer products and quotients one bit per cycle. It keeps a private pair of result registers, HI and LO. A caller sends a command on a valid/ready channel. The 6-bit function code selects one of eight actions:

- signed or unsigned multiply
- signed or unsigned divide
- load HI or LO from operand A
- read HI or LO back

A multiply or divide raises `busy` for one setup cycle plus one cycle per operand bit. It then writes both result registers in a single edge.

Reads return their value on a separate valid/ready response channel. The command channel applies back-pressure by dropping `cmd_ready`, in two situations:

- while an arithmetic sequence runs;
- while a read response is still waiting for `rsp_ready`.

So a read or a load issued during a computation waits and takes effect only after the new HI/LO values are in place. A command transfers on a rising edge where `cmd_valid` and `cmd_ready` are both high. A response transfers on an edge where `rsp_valid` and `rsp_ready` are both high. Until that happens, `rsp_valid` and `rsp_data` hold steady.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, `busy` and `rsp_valid` are low, `cmd_ready` is high, and both HI and LO read back as zero.
- R2: Function codes are decoded as follows:
  - 0x18: signed multiply
  - 0x19: unsigned multiply
  - 0x1a: signed divide
  - 0x1b: unsigned divide
  - 0x10: read HI
  - 0x12: read LO
  - 0x11: load HI from `cmd_a`
  - 0x13: load LO from `cmd_a`
- R3: A signed multiply (0x18) forms the 64-bit two's-complement product of `cmd_a` and `cmd_b`. The upper half goes to HI and the lower half to LO.
- R4: An unsigned multiply (0x19) forms the 64-bit unsigned product. The upper half goes to HI and the lower half to LO.
- R5: A signed divide (0x1a) with a non-zero divisor writes two results:
  - LO gets the quotient, truncated toward zero.
  - HI gets the remainder, which carries the sign of the dividend. The case 0x80000000 / -1 gives LO = 0x80000000 and HI = 0.
- R6: An unsigned divide (0x1b) with a non-zero divisor puts the unsigned quotient in LO and the remainder in HI.
- R7: A divide by zero, signed or unsigned, takes the normal number of cycles. It writes LO = 0xFFFFFFFF and HI = the dividend.
- R8: After an arithmetic command transfers, `busy` is high for exactly WIDTH+1 cycles, and `cmd_ready` is low during all of them.
- R9: A load writes the selected register on its transfer edge. A read raises `rsp_valid` on the next cycle with the register value. While `rsp_ready` is low, `rsp_valid` and `rsp_data` stay unchanged and `cmd_ready` stays low.
- R10: A function code outside the eight listed is accepted and changes neither HI nor LO.
- R11: A read offered while `busy` is high is held off. Once accepted, it returns the result of the operation that was running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_func | input | 6 | Function code (see R2) |
| cmd_a | input | WIDTH | First operand / dividend / load value |
| cmd_b | input | WIDTH | Second operand / divisor |
| busy | output | 1 | Multiply or divide sequence in progress |
| rsp_valid | output | 1 | Read response available |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | WIDTH | Value of HI or LO for a read |

## Verification
The bench builds the block with the default WIDTH of 32. At this width, the bench's 64-bit reference arithmetic covers every operand extreme:

- full-scale negative products;
- the 0x80000000 / -1 quotient;
- divide-by-zero with negative dividends.

The iteration counter runs its full 0 to 31 range, so the busy length of 33 cycles is checked exactly. Random operand pairs, some of them masked to small values, exercise both the carry path of the shift-add loop and the subtract path of the restoring-division loop.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  localparam int FUNC_W = 6;

  localparam logic [FUNC_W-1:0] FN_RD_HI = 6'h10;
  localparam logic [FUNC_W-1:0] FN_WR_HI = 6'h11;
  localparam logic [FUNC_W-1:0] FN_RD_LO = 6'h12;
  localparam logic [FUNC_W-1:0] FN_WR_LO = 6'h13;
  localparam logic [FUNC_W-1:0] FN_MUL_S = 6'h18;
  localparam logic [FUNC_W-1:0] FN_MUL_U = 6'h19;
  localparam logic [FUNC_W-1:0] FN_DIV_S = 6'h1a;
  localparam logic [FUNC_W-1:0] FN_DIV_U = 6'h1b;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_SETUP = 2'd1,
    SQ_RUN   = 2'd2
  } seq_state_t;

  function automatic logic is_arith(input logic [FUNC_W-1:0] f);
    return (f == FN_MUL_S) || (f == FN_MUL_U) || (f == FN_DIV_S) || (f == FN_DIV_U);
  endfunction
endpackage

// File: rtl/muldiv_seq.sv
module muldiv_seq
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic setup,
  output logic step,
  output logic last
);
  localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WIDTH - 1);

  seq_state_t       state;
  logic [CNT_W-1:0] iter;

  assign busy  = (state != SQ_IDLE);
  assign setup = (state == SQ_SETUP);
  assign step  = (state == SQ_RUN);
  assign last  = step && (iter == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      iter  <= '0;
    end else begin
      unique case (state)
        SQ_IDLE: if (start) state <= SQ_SETUP;
        SQ_SETUP: begin
          state <= SQ_RUN;
          iter  <= '0;
        end
        SQ_RUN: begin
          if (iter == CNT_LAST) state <= SQ_IDLE;
          else iter <= iter + 1'b1;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/muldiv_engine.sv
module muldiv_engine #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             op_div,
  input  logic             op_signed,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             setup,
  input  logic             step,
  output logic [WIDTH-1:0] res_hi,
  output logic [WIDTH-1:0] res_lo
);
  localparam int PW = 2 * WIDTH;

  logic [WIDTH-1:0] raw_a, raw_b;
  logic             mode_div, mode_sgn;
  logic [WIDTH:0]   acc;
  logic [WIDTH-1:0] low, opnd;
  logic             neg_main, neg_rem, div_zero;

  logic [WIDTH:0]   acc_n;
  logic [WIDTH-1:0] low_n;

  function automatic logic [WIDTH-1:0] magn(input logic [WIDTH-1:0] v, input logic sgn);
    return (sgn && v[WIDTH-1]) ? (~v + 1'b1) : v;
  endfunction

  // one iteration: shift-add for multiply, restoring subtract for divide
  logic [WIDTH:0]   add_sum;
  logic [WIDTH:0]   shifted;
  logic [WIDTH+1:0] trial;
  always_comb begin
    add_sum = acc + (low[0] ? {1'b0, opnd} : '0);
    shifted = {acc[WIDTH-1:0], low[WIDTH-1]};
    trial   = {1'b0, shifted} - {2'b00, opnd};
    if (!mode_div) begin
      acc_n = {1'b0, add_sum[WIDTH:1]};
      low_n = {add_sum[0], low[WIDTH-1:1]};
    end else if (!trial[WIDTH+1]) begin
      acc_n = trial[WIDTH:0];
      low_n = {low[WIDTH-2:0], 1'b1};
    end else begin
      acc_n = shifted;
      low_n = {low[WIDTH-2:0], 1'b0};
    end
  end

  // sign fix-up applied to the value after the final iteration
  logic [PW-1:0]    prod, prod_f;
  logic [WIDTH-1:0] quo_f, rem_f;
  always_comb begin
    prod   = {acc_n[WIDTH-1:0], low_n};
    prod_f = neg_main ? (~prod + 1'b1) : prod;
    quo_f  = neg_main ? (~low_n + 1'b1) : low_n;
    rem_f  = neg_rem ? (~acc_n[WIDTH-1:0] + 1'b1) : acc_n[WIDTH-1:0];
    if (!mode_div) begin
      res_hi = prod_f[PW-1:WIDTH];
      res_lo = prod_f[WIDTH-1:0];
    end else if (div_zero) begin
      res_hi = raw_a;
      res_lo = '1;
    end else begin
      res_hi = rem_f;
      res_lo = quo_f;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_a    <= '0;
      raw_b    <= '0;
      mode_div <= 1'b0;
      mode_sgn <= 1'b0;
      acc      <= '0;
      low      <= '0;
      opnd     <= '0;
      neg_main <= 1'b0;
      neg_rem  <= 1'b0;
      div_zero <= 1'b0;
    end else if (start) begin
      raw_a    <= a_in;
      raw_b    <= b_in;
      mode_div <= op_div;
      mode_sgn <= op_signed;
    end else if (setup) begin
      acc      <= '0;
      low      <= magn(raw_a, mode_sgn);
      opnd     <= magn(raw_b, mode_sgn);
      neg_main <= mode_sgn && (raw_a[WIDTH-1] ^ raw_b[WIDTH-1]);
      neg_rem  <= mode_sgn && mode_div && raw_a[WIDTH-1];
      div_zero <= (raw_b == '0);
    end else if (step) begin
      acc <= acc_n;
      low <= low_n;
    end
  end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [5:0]       cmd_func,
  input  logic [WIDTH-1:0] cmd_a,
  input  logic [WIDTH-1:0] cmd_b,
  output logic             busy,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [WIDTH-1:0] rsp_data
);
  logic             take, start, setup, step, last;
  logic [WIDTH-1:0] reg_hi, reg_lo, res_hi, res_lo;

  assign cmd_ready = !busy && !(rsp_valid && !rsp_ready);
  assign take      = cmd_valid && cmd_ready;
  assign start     = take && is_arith(cmd_func);

  muldiv_seq #(.WIDTH(WIDTH)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .setup (setup),
    .step  (step),
    .last  (last)
  );

  muldiv_engine #(.WIDTH(WIDTH)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op_div    (cmd_func[1]),
    .op_signed (!cmd_func[0]),
    .a_in      (cmd_a),
    .b_in      (cmd_b),
    .setup     (setup),
    .step      (step),
    .res_hi    (res_hi),
    .res_lo    (res_lo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_hi <= '0;
      reg_lo <= '0;
    end else if (last) begin
      reg_hi <= res_hi;
      reg_lo <= res_lo;
    end else if (take && cmd_func == FN_WR_HI) begin
      reg_hi <= cmd_a;
    end else if (take && cmd_func == FN_WR_LO) begin
      reg_lo <= cmd_a;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (take && (cmd_func == FN_RD_HI || cmd_func == FN_RD_LO)) begin
      rsp_valid <= 1'b1;
      rsp_data  <= (cmd_func == FN_RD_HI) ? reg_hi : reg_lo;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [5:0]       cmd_func,
  input logic             busy,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [WIDTH-1:0] rsp_data
);
  localparam int CW = $clog2(WIDTH + 3);
  logic [CW-1:0] busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1'b1;
    else busy_len <= '0;
  end

  assert_no_ready_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);

  assert_busy_span_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_len == CW'(WIDTH + 1)));

  assert_busy_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_len <= CW'(WIDTH)));

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && is_arith(cmd_func)) |=> busy);

  assert_read_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && (cmd_func == FN_RD_HI || cmd_func == FN_RD_LO)) |=> rsp_valid);

  assert_resp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
endmodule

bind muldiv_unit muldiv_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_func  (cmd_func),
  .busy      (busy),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data)
);

// File: tb/test_muldiv_unit.sv
`timescale 1ns/1ps
module test_muldiv_unit;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic         cmd_ready;
  logic [5:0]   cmd_func = '0;
  logic [W-1:0] cmd_a = '0, cmd_b = '0;
  logic         busy;
  logic         rsp_valid;
  logic         rsp_ready = 1'b0;
  logic [W-1:0] rsp_data;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  muldiv_unit #(.WIDTH(W)) i_muldiv_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_func(cmd_func), .cmd_a(cmd_a), .cmd_b(cmd_b), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the transfer edge
  task automatic send(input logic [5:0] f, input logic [W-1:0] a, input logic [W-1:0] b);
    cmd_func  = f;
    cmd_a     = a;
    cmd_b     = b;
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic read_reg(input logic [5:0] f, output logic [W-1:0] v);
    send(f, '0, '0);
    while (!rsp_valid) @(negedge clk);
    v = rsp_data;
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  function automatic void model(input logic [5:0] f, input logic [W-1:0] a, input logic [W-1:0] b,
                                output logic [W-1:0] eh, output logic [W-1:0] el);
    longint sa, sb, q, r;
    logic [63:0] p;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    case (f)
      6'h18: p = 64'(sa * sb);
      6'h19: p = {32'd0, a} * {32'd0, b};
      6'h1a: begin
        if (b == 0) p = {a, 32'hFFFFFFFF};
        else begin q = sa / sb; r = sa % sb; p = {r[31:0], q[31:0]}; end
      end
      default: begin
        if (b == 0) p = {a, 32'hFFFFFFFF};
        else p = {a % b, a / b};
      end
    endcase
    eh = p[63:32];
    el = p[31:0];
  endfunction

  function automatic string tag(input logic [5:0] f, input logic [W-1:0] b);
    if ((f == 6'h1a || f == 6'h1b) && b == 0) return "R7";
    case (f)
      6'h18: return "R3";
      6'h19: return "R4";
      6'h1a: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic run_op(input logic [5:0] f, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] eh, el, vh, vl;
    model(f, a, b, eh, el);
    send(f, a, b);
    wait_idle();
    read_reg(6'h10, vh);
    read_reg(6'h12, vl);
    check({tag(f, b), " HI"}, vh, eh);
    check({tag(f, b), " LO"}, vl, el);
  endtask

  initial begin : watchdog
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++;
        tests++;
        $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin : main
    logic [W-1:0] v, eh, el, held;
    int n;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 busy", {31'd0, busy}, '0);
    check("R1 rsp_valid", {31'd0, rsp_valid}, '0);
    check("R1 cmd_ready", {31'd0, cmd_ready}, 32'd1);
    read_reg(6'h10, v); check("R1 HI", v, '0);
    read_reg(6'h12, v); check("R1 LO", v, '0);

    // R9 / R2 loads and reads
    send(6'h11, 32'hCAFE0001, '0);
    send(6'h13, 32'h1234ABCD, '0);
    read_reg(6'h10, v); check("R9 load HI", v, 32'hCAFE0001);
    read_reg(6'h12, v); check("R9 load LO", v, 32'h1234ABCD);

    // R9 response hold under back-pressure
    send(6'h10, '0, '0);
    held = rsp_data;
    repeat (3) @(negedge clk);
    check("R9 hold valid", {31'd0, rsp_valid}, 32'd1);
    check("R9 hold data", rsp_data, held);
    check("R9 hold ready", {31'd0, cmd_ready}, '0);
    rsp_ready = 1'b1; @(posedge clk); @(negedge clk); rsp_ready = 1'b0;
    check("R9 drained", {31'd0, rsp_valid}, '0);

    // R10 unknown code
    send(6'h2a, 32'hFFFF0000, 32'h1);
    read_reg(6'h10, v); check("R10 HI kept", v, 32'hCAFE0001);
    read_reg(6'h12, v); check("R10 LO kept", v, 32'h1234ABCD);

    // R8 busy length and back-pressure
    send(6'h18, 32'd7, 32'd9);
    n = 0;
    while (busy) begin
      if (cmd_ready) check("R8 ready low", {31'd0, cmd_ready}, '0);
      n++;
      @(negedge clk);
    end
    check("R8 busy cycles", 32'(n), 32'(W + 1));
    read_reg(6'h12, v); check("R3 small", v, 32'd63);

    // R11 read while busy returns the new result
    model(6'h1b, 32'd1000, 32'd7, eh, el);
    send(6'h1b, 32'd1000, 32'd7);
    read_reg(6'h10, v); check("R11 HI after wait", v, eh);
    // load held off until completion, result HI stays
    send(6'h19, 32'hFFFFFFFF, 32'hFFFFFFFF);
    send(6'h13, 32'h55AA55AA, '0);
    read_reg(6'h12, v); check("R11 load after op", v, 32'h55AA55AA);
    read_reg(6'h10, v); check("R4 HI kept by load", v, 32'hFFFFFFFE);

    // directed corners
    run_op(6'h18, 32'hFFFFFFFF, 32'hFFFFFFFF);
    run_op(6'h18, 32'h80000000, 32'h80000000);
    run_op(6'h18, 32'h80000000, 32'h7FFFFFFF);
    run_op(6'h18, 32'hABCD1234, 32'h00000000);
    run_op(6'h19, 32'hFFFFFFFF, 32'hFFFFFFFF);
    run_op(6'h1a, 32'hFFFFFFF9, 32'd2);
    run_op(6'h1a, 32'd7, 32'hFFFFFFFE);
    run_op(6'h1a, 32'h80000000, 32'hFFFFFFFF);
    run_op(6'h1a, 32'd5, 32'd9);
    run_op(6'h1b, 32'hFFFFFFFF, 32'd1);
    run_op(6'h1b, 32'h80000000, 32'hFFFFFFFF);
    run_op(6'h1a, 32'hFFFFFF00, 32'd0);
    run_op(6'h1b, 32'h87654321, 32'd0);

    // constrained random
    for (int i = 0; i < 60; i++) begin
      logic [5:0] f;
      logic [W-1:0] a, b;
      f = 6'h18 + 6'($urandom_range(0, 3));
      a = $urandom;
      b = $urandom;
      if (i % 3 == 0) b = b & 32'h000000FF;
      if (i % 5 == 0) a = a & 32'h0000FFFF;
      if (i % 7 == 0) b = 32'hFFFFFFFF - (b & 32'hF);
      run_op(f, a, b);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule